// File: doc/BRIEF.md
# Synthesizer Divider Core

This block is the digital side of a frequency synthesizer, modelled on a single fast system clock `clk`. Each source clock is represented by a tick strobe, and one tick stands for one period of that source. A reference tick comes either from the crystal oscillator or from a test clock input. The block divides it by 16 to give the compare pulse the phase detector uses. A feedback counter divides the VCO tick stream by twice a 9-bit value M. A shared output divider produces several true/inverted output pairs. Its source is the VCO tick stream in PLL mode, or the reference ticks directly in bypass mode. The division ratio comes from a 3-bit code, and every even ratio gives an equal high and low time.

The output divider is a four-state machine. `S_IDLE` is the state after reset or after a restart. `S_HIGH` and `S_LOW` are the two halves of a divided period. `S_PASS` is the divide-by-1 mode. The named transitions are as follows. T_START goes from `S_IDLE` to `S_HIGH` or `S_PASS` on the first source tick. T_HALF goes from `S_HIGH` to `S_LOW` after half a period. T_WRAP goes from `S_LOW` to `S_HIGH` at a period boundary, and the ratio is reloaded there. T_ENTER_PASS is taken at a boundary, from `S_LOW`, when the new ratio is 1. T_LEAVE_PASS goes from `S_PASS` to `S_HIGH` on a tick when the code no longer selects 1. T_RESTART goes from any state to `S_IDLE` when the mode select changes. The master reset is asynchronous and active high. It clears all counters and all states.

Top module: `synth_div_core`

## Requirements
- R1: While `mr` is high, every `fout` bit is 0, every `fout_n` bit is 1, and `ref_cmp` and `fb_cmp` are 0. The dividers restart from `S_IDLE` with cleared counts after `mr` falls.
- R2: The ratio for each `n_code` value is: 3'b100 gives 1, 3'b000 and 3'b101 give 2, 3'b001 and 3'b110 give 4, 3'b010 and 3'b111 give 8, and 3'b011 gives 16.
- R3: For an even ratio R, the true output stays high for R/2 source ticks and low for R/2 source ticks. The first tick after idle starts a high half. Each tick is seen on the outputs one `clk` cycle after the edge that samples it.
- R4: With ratio 1, the true output is high for exactly the cycle after each source tick and is low otherwise.
- R5: A new `n_code` is loaded only at a period boundary. That boundary is the tick that ends a low half, or any tick while in divide-by-1, so a half that has started always completes at the old ratio.
- R6: All output pairs carry the same value, and each `fout_n` bit is the complement of its `fout` bit.
- R7: `pll_mode` = 1 feeds VCO ticks to the output divider. `pll_mode` = 0 (bypass) feeds the selected reference ticks, and VCO ticks then do not affect `fout`.
- R8: A change of `pll_mode`, compared with its value in the previous cycle, sends the output divider to `S_IDLE`. The outputs read low on the next cycle, and any source tick in that cycle is ignored.
- R9: `ref_sel` = 1 takes the reference ticks from `xtal_tick`, and `ref_sel` = 0 takes them from `tclk_tick`.
- R10: `ref_cmp` pulses for one cycle after every 16th selected reference tick, whatever the state of `pll_mode`.
- R11: `fb_cmp` pulses for one cycle after every 2·M VCO ticks, for M from 1 to 511 held steady since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all tick strobes |
| mr | input | 1 | Asynchronous master reset, active high |
| ref_sel | input | 1 | Reference source: 1 crystal, 0 test clock |
| xtal_tick | input | 1 | One crystal oscillator period |
| tclk_tick | input | 1 | One test clock period |
| vco_tick | input | 1 | One VCO period |
| pll_mode | input | 1 | 1 selects the VCO path, 0 selects bypass |
| m_val | input | 9 | Feedback multiplier M |
| n_code | input | 3 | Output ratio code |
| fout | output | NUM_PAIRS | True outputs |
| fout_n | output | NUM_PAIRS | Inverted outputs |
| ref_cmp | output | 1 | Divided reference pulse for the phase detector |
| fb_cmp | output | 1 | Divided feedback pulse for the phase detector |

## Verification
Two events can land in the same cycle. A source tick can arrive in the cycle where `pll_mode` flips, and a period boundary can arrive in the cycle where `n_code` changes. The bench provokes both collisions. It toggles `pll_mode` every few cycles under dense random ticks, and it rewrites `n_code` every three cycles during continuous ticking. A behavioural phase-counter model judges each cycle. In that model a mode change wins over the tick, and the code is read only when the phase wraps.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int NCODE_W = 3;
    localparam int RATIO_W = 5;
    localparam int HALF_W  = RATIO_W - 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2,
        S_PASS = 2'd3
    } div_state_e;

    // Non-monotonic ratio map: upper half of the code space is the fine range.
    function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [NCODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'b000:  r = 5'd2;
            3'b001:  r = 5'd4;
            3'b010:  r = 5'd8;
            3'b011:  r = 5'd16;
            3'b100:  r = 5'd1;
            3'b101:  r = 5'd2;
            3'b110:  r = 5'd4;
            default: r = 5'd8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sd_ref_prediv.sv
module sd_ref_prediv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic mr,
    input  logic tick,
    output logic pulse
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick) begin
                if (cnt_q == LAST) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/sd_fb_div.sv
module sd_fb_div #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           mr,
    input  logic           tick,
    input  logic [M_W-1:0] m_val,
    output logic           pulse
);
    localparam int CNT_W = M_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             pulse_q;

    // Period is twice M: terminal count is 2M-1.
    assign last = {m_val, 1'b0} - 1'b1;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick) begin
                if (cnt_q == last) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/sd_out_fsm.sv
module sd_out_fsm
    import synth_div_pkg::*;
(
    input  logic               clk,
    input  logic               mr,
    input  logic               src_tick,
    input  logic               mode,
    input  logic [NCODE_W-1:0] n_code,
    output logic               out_true
);
    div_state_e         state_q, state_d;
    logic [HALF_W-1:0]  cnt_q, cnt_d;
    logic [HALF_W-1:0]  half_q, half_d;
    logic               pass_q;
    logic               mode_q;
    logic               restart;
    logic [RATIO_W-1:0] new_ratio;
    logic [HALF_W-1:0]  new_half;
    logic               new_is_one;
    logic               half_done;

    assign restart    = (mode != mode_q);
    assign new_ratio  = code_to_ratio(n_code);
    assign new_half   = new_ratio[RATIO_W-1:1];
    assign new_is_one = (new_ratio == RATIO_W'(1));
    assign half_done  = (cnt_q == (half_q - 1'b1));

    // State register
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            half_q  <= HALF_W'(1);
            pass_q  <= 1'b0;
            mode_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
            pass_q  <= src_tick;
            mode_q  <= mode;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        half_d  = half_q;
        if (restart) begin
            state_d = S_IDLE;                       // T_RESTART
            cnt_d   = '0;
        end else if (src_tick) begin
            unique case (state_q)
                S_IDLE, S_PASS: begin               // T_START / T_LEAVE_PASS
                    cnt_d   = '0;
                    half_d  = new_half;
                    state_d = new_is_one ? S_PASS : S_HIGH;
                end
                S_HIGH: begin
                    if (half_done) begin            // T_HALF
                        state_d = S_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_LOW: begin
                    if (half_done) begin            // T_WRAP / T_ENTER_PASS
                        cnt_d   = '0;
                        half_d  = new_half;
                        state_d = new_is_one ? S_PASS : S_HIGH;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            S_HIGH:  out_true = 1'b1;
            S_PASS:  out_true = pass_q;
            S_IDLE,
            S_LOW:   out_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/synth_div_core.sv
module synth_div_core #(
    parameter int NUM_PAIRS = 2,
    parameter int PREDIV    = 16,
    parameter int M_W       = 9
) (
    input  logic                 clk,
    input  logic                 mr,
    input  logic                 ref_sel,
    input  logic                 xtal_tick,
    input  logic                 tclk_tick,
    input  logic                 vco_tick,
    input  logic                 pll_mode,
    input  logic [M_W-1:0]       m_val,
    input  logic [2:0]           n_code,
    output logic [NUM_PAIRS-1:0] fout,
    output logic [NUM_PAIRS-1:0] fout_n,
    output logic                 ref_cmp,
    output logic                 fb_cmp
);
    logic ref_tick;
    logic src_tick;
    logic out_true;

    assign ref_tick = ref_sel ? xtal_tick : tclk_tick;
    assign src_tick = pll_mode ? vco_tick : ref_tick;

    sd_ref_prediv #(.DIV(PREDIV)) u_prediv (
        .clk   (clk),
        .mr    (mr),
        .tick  (ref_tick),
        .pulse (ref_cmp)
    );

    sd_fb_div #(.M_W(M_W)) u_fbdiv (
        .clk   (clk),
        .mr    (mr),
        .tick  (vco_tick),
        .m_val (m_val),
        .pulse (fb_cmp)
    );

    sd_out_fsm u_outfsm (
        .clk      (clk),
        .mr       (mr),
        .src_tick (src_tick),
        .mode     (pll_mode),
        .n_code   (n_code),
        .out_true (out_true)
    );

    // Every pair is fed by the one divider state, so they stay aligned.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign fout[g]   = out_true;
        assign fout_n[g] = ~out_true;
    end

endmodule

// File: rtl/synth_div_core_chk.sv
module synth_div_core_chk #(
    parameter int NUM_PAIRS = 2
) (
    input logic                 clk,
    input logic                 mr,
    input logic                 pll_mode,
    input logic [NUM_PAIRS-1:0] fout,
    input logic [NUM_PAIRS-1:0] fout_n,
    input logic                 ref_cmp,
    input logic                 fb_cmp
);
    p_reset_levels_r1: assert property (@(posedge clk)
        mr |-> (fout == '0 && fout_n == '1 && !ref_cmp && !fb_cmp));

    p_restart_low_r8: assert property (@(posedge clk) disable iff (mr)
        (!$past(mr) && pll_mode != $past(pll_mode)) |=> (fout == '0));

    p_ref_spacing_r10: assert property (@(posedge clk) disable iff (mr)
        ref_cmp |=> !ref_cmp);

    p_fb_spacing_r11: assert property (@(posedge clk) disable iff (mr)
        fb_cmp |=> !fb_cmp);
endmodule

bind synth_div_core synth_div_core_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
    .clk      (clk),
    .mr       (mr),
    .pll_mode (pll_mode),
    .fout     (fout),
    .fout_n   (fout_n),
    .ref_cmp  (ref_cmp),
    .fb_cmp   (fb_cmp)
);

// File: tb/synth_div_core_tb_top.sv
module synth_div_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PAIRS  = 2;

    logic                 clk = 1'b0;
    logic                 mr = 1'b1;
    logic                 ref_sel = 1'b1;
    logic                 xtal_tick = 1'b0;
    logic                 tclk_tick = 1'b0;
    logic                 vco_tick = 1'b0;
    logic                 pll_mode = 1'b1;
    logic [8:0]           m_val = 9'd3;
    logic [2:0]           n_code = 3'b000;
    logic [NUM_PAIRS-1:0] fout, fout_n;
    logic                 ref_cmp, fb_cmp;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    synth_div_core #(.NUM_PAIRS(NUM_PAIRS)) dut_i (
        .clk(clk), .mr(mr), .ref_sel(ref_sel), .xtal_tick(xtal_tick),
        .tclk_tick(tclk_tick), .vco_tick(vco_tick), .pll_mode(pll_mode),
        .m_val(m_val), .n_code(n_code), .fout(fout), .fout_n(fout_n),
        .ref_cmp(ref_cmp), .fb_cmp(fb_cmp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: a phase counter within the current period.
    int ph, ratio, rcnt, fcnt;
    bit idle, prev_mode, exp_out, exp_ref, exp_fb;

    function automatic int ratio_of(input logic [2:0] c);
        return c[2] ? (1 << c[1:0]) : (2 << c[1:0]);
    endfunction

    task automatic check_bit(input string req, input string what,
                             input logic [NUM_PAIRS-1:0] act,
                             input logic [NUM_PAIRS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit rt, st;
        if (mr) begin
            idle = 1; ph = 0; ratio = 2; rcnt = 0; fcnt = 0;
            prev_mode = 1; exp_out = 0; exp_ref = 0; exp_fb = 0;
        end else begin
            rt = ref_sel ? xtal_tick : tclk_tick;
            st = pll_mode ? vco_tick : rt;
            exp_ref = 0;
            if (rt) begin rcnt++; if (rcnt == 16) begin rcnt = 0; exp_ref = 1; end end
            exp_fb = 0;
            if (vco_tick) begin fcnt++; if (fcnt == 2*int'(m_val)) begin fcnt = 0; exp_fb = 1; end end
            if (pll_mode != prev_mode) begin
                idle = 1; exp_out = 0;
            end else if (st) begin
                if (idle) begin idle = 0; ratio = ratio_of(n_code); ph = 0; end
                else begin
                    ph++;
                    if (ph >= ratio) begin ph = 0; ratio = ratio_of(n_code); end
                end
                exp_out = (ratio == 1) ? 1'b1 : (ph < ratio/2);
            end else begin
                exp_out = idle ? 1'b0 : ((ratio == 1) ? 1'b0 : (ph < ratio/2));
            end
            prev_mode = pll_mode;
        end
        #(CLK_PERIOD/4);
        if (!finished) begin
            check_bit(cur_req, "fout", fout, {NUM_PAIRS{exp_out}});
            check_bit("R6", "fout_n", fout_n, ~{NUM_PAIRS{exp_out}});
            check_bit("R10", "ref_cmp", NUM_PAIRS'(ref_cmp), NUM_PAIRS'(exp_ref));
            check_bit("R11", "fb_cmp", NUM_PAIRS'(fb_cmp), NUM_PAIRS'(exp_fb));
        end
    end

    task automatic run(input int n, input int pv, input int px, input int pt,
                       input int code_every, input int mode_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vco_tick  = ($urandom_range(99) < pv);
            xtal_tick = ($urandom_range(99) < px);
            tclk_tick = ($urandom_range(99) < pt);
            if (code_every > 0 && (i % code_every) == 0) n_code = 3'($urandom_range(7));
            if (mode_every > 0 && i > 0 && (i % mode_every) == 0) pll_mode = ~pll_mode;
        end
    endtask

    task automatic do_reset(input logic [8:0] m);
        @(negedge clk);
        cur_req = "R1";
        mr = 1'b1; pll_mode = 1'b1; m_val = m;
        run(4, 50, 50, 50, 0, 0);
        @(negedge clk);
        mr = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset(9'd3);
        // R2: every code with a continuous tick stream
        cur_req = "R2";
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            n_code = 3'(c);
            run(48, 100, 30, 30, 0, 0);
        end
        // R3: sparse random ticks at even ratios
        cur_req = "R3";
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            n_code = 3'(c);
            run(80, 40, 30, 30, 0, 0);
        end
        // R4: divide-by-1 pass-through
        cur_req = "R4";
        @(negedge clk);
        n_code = 3'b100;
        run(60, 50, 30, 30, 0, 0);
        // R5: code rewritten often, collides with period boundaries
        cur_req = "R5";
        run(300, 100, 30, 30, 3, 0);
        run(200, 60, 30, 30, 2, 0);
        // R7: bypass, VCO ticks must not matter
        cur_req = "R7";
        @(negedge clk);
        pll_mode = 1'b0;
        run(200, 90, 60, 20, 17, 0);
        // R9: both reference sources
        cur_req = "R9";
        @(negedge clk);
        ref_sel = 1'b0;
        run(200, 90, 10, 70, 19, 0);
        @(negedge clk);
        ref_sel = 1'b1;
        run(100, 90, 70, 10, 0, 0);
        // R8: mode flips during dense ticks
        cur_req = "R8";
        run(300, 90, 90, 90, 11, 7);
        run(100, 100, 100, 100, 5, 3);
        // R1 again mid-run, then R11 feedback with other M values
        do_reset(9'd1);
        cur_req = "R11";
        @(negedge clk);
        pll_mode = 1'b1;
        run(200, 60, 40, 40, 13, 0);
        do_reset(9'd300);
        cur_req = "R11";
        run(2500, 100, 50, 50, 0, 0);
        do_reset(9'd511);
        cur_req = "R11";
        run(1100, 100, 50, 50, 0, 0);
        finish_run();
    end

endmodule